// File: doc/BRIEF.md
# Per-Core Register Window Decoder

This block sits between a shared register port and a bank of per-core registers. Every request carries the identity of the core that issued it. Two address windows lead to the per-core registers. In the local window a request always reaches the registers of the issuing core. In the other window it reaches the core named by the issuing core's redirect register, which is one small register per core held inside this block.

The block answers four kinds of word itself. These are the redirect register, an identity word that reports which core a request actually reached, a control word that always reads zero, and a user-visible mirror of the shared counter. The remaining bank offsets are passed on to the external per-core registers. That pass-through carries the target core, a register index and a write strobe, and the bank returns its read data in the same cycle. Read data leaves the block one cycle after the request, with the same latency for both windows.

Address map: the top two address bits select the window (0 local, 1 other, 2 user counter, 3 unused). The remaining bits are a word offset. In the local and other windows, offset 0 is control, 1 is redirect, 2 is identity, and offsets 3 up to 3+BANK_REGS-1 reach bank register (offset-3). In the user window, offset 0 is the counter low word and 1 is the high word.

Top module: `core_win`

## Requirements
- R1: A bank-register access in the local window (window 0, offsets 3..3+BANK_REGS-1) raises bank_valid with bank_core equal to req_core, bank_reg equal to offset-3, bank_we equal to req_wr and bank_wdata equal to req_wdata, all in the request cycle.
- R2: A bank-register access in the other window (window 1) raises bank_valid with bank_core equal to the requester's redirect register value, and bank_reg equal to offset-3.
- R3: Each core's redirect register resets to 0 and reads back zero-extended at offset 1. A write stores req_wdata only when the full data word is below NUM_CORES; otherwise the write is ignored.
- R4: The identity word (offset 2) reads the index of the core the request reaches. That is req_core in the local window and the redirected core in the other window.
- R5: In the user window, offset 0 reads shared_count and offset 1 reads 0. Writes there change no state and raise no bank_valid.
- R6: The control word (offset 0 of the local and other windows) always reads 0 and ignores writes.
- R7: Every other offset reads 0, ignores writes and raises no bank_valid. This includes all of window 3.
- R8: rd_valid is 1 in exactly the cycle after an accepted read and 0 otherwise. rd_data carries the value selected at the request cycle, and bank reads return bank_rdata as sampled in that cycle.
- R9: A write to offset 1 through the other window updates the redirect register of the redirected core, not that of the requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_core | input | CW | Index of the requesting core |
| req_addr | input | AW | Window (top two bits) and word offset |
| req_wdata | input | DW | Write data |
| shared_count | input | DW | Shared counter value to mirror |
| bank_rdata | input | DW | Read data from the addressed bank register, same cycle |
| bank_valid | output | 1 | Access to an external bank register |
| bank_we | output | 1 | Write strobe for the bank register |
| bank_core | output | CW | Core whose bank is addressed |
| bank_reg | output | BRW | Bank register index |
| bank_wdata | output | DW | Write data to the bank |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | DW | Read data |

## Verification
The bench builds the block with three cores, two bank registers and a six-bit address. Three is not a power of two, so the redirect width has an unused code (3). This makes the out-of-range write filter visible, and a 32-bit value whose low bits are in range but whose upper bits are not is also rejected. Six address bits make it cheap to sweep every core against every address in every window. The sweep is repeated after the redirect registers are set to distinct values, after a redirect write through the other window, and after an all-ones write sweep that must leave everything unchanged.

// File: rtl/core_win_pkg.sv
package core_win_pkg;

   // window codes held in the top two address bits
   typedef enum logic [1:0] {
      WIN_LOCAL = 2'd0,
      WIN_OTHER = 2'd1,
      WIN_USER  = 2'd2,
      WIN_NONE  = 2'd3
   } win_e;

   // what a decoded access resolves to
   typedef enum logic [2:0] {
      K_ZERO,
      K_CTL,
      K_REDIR,
      K_IDENT,
      K_BANK,
      K_CNT_LO,
      K_CNT_HI
   } kind_e;

   localparam int OFS_CTL    = 0;
   localparam int OFS_REDIR  = 1;
   localparam int OFS_IDENT  = 2;
   localparam int OFS_BANK0  = 3;
   localparam int OFS_CNT_LO = 0;
   localparam int OFS_CNT_HI = 1;

endpackage

// File: rtl/core_win_decode.sv
module core_win_decode
   import core_win_pkg::*;
#(
   parameter int AW        = 8,
   parameter int BANK_REGS = 4,
   parameter int BRW       = 2
) (
   input  logic [AW-1:0]  addr,
   output win_e           win,
   output kind_e          kind,
   output logic [BRW-1:0] bank_idx
);
   localparam int OW = AW - 2;

   logic [OW-1:0] off;

   assign win = win_e'(addr[AW-1:AW-2]);
   assign off = addr[OW-1:0];

   always_comb begin
      kind     = K_ZERO;
      bank_idx = '0;
      unique case (win)
         WIN_LOCAL, WIN_OTHER: begin
            if (32'(off) == OFS_CTL) begin
               kind = K_CTL;
            end else if (32'(off) == OFS_REDIR) begin
               kind = K_REDIR;
            end else if (32'(off) == OFS_IDENT) begin
               kind = K_IDENT;
            end else if (32'(off) >= OFS_BANK0 &&
                         32'(off) <  OFS_BANK0 + BANK_REGS) begin
               kind     = K_BANK;
               bank_idx = BRW'(32'(off) - OFS_BANK0);
            end
         end
         WIN_USER: begin
            if (32'(off) == OFS_CNT_LO) begin
               kind = K_CNT_LO;
            end else if (32'(off) == OFS_CNT_HI) begin
               kind = K_CNT_HI;
            end
         end
         default: kind = K_ZERO;
      endcase
   end

endmodule

// File: rtl/core_win_redir.sv
module core_win_redir #(
   parameter int NUM_CORES = 4,
   parameter int CW        = 2,
   parameter int DW        = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [CW-1:0] wr_core,
   input  logic [DW-1:0] wdata,
   input  logic [CW-1:0] rd_a,
   input  logic [CW-1:0] rd_b,
   output logic [CW-1:0] sel_a,
   output logic [CW-1:0] sel_b
);
   logic [CW-1:0] regs [NUM_CORES];
   logic          in_range;

   // the whole data word must name an existing core
   assign in_range = wdata < DW'(NUM_CORES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_CORES; i++) regs[i] <= '0;
      end else if (we && in_range) begin
         for (int i = 0; i < NUM_CORES; i++) begin
            if (32'(wr_core) == i) regs[i] <= wdata[CW-1:0];
         end
      end
   end

   assign sel_a = (32'(rd_a) < NUM_CORES) ? regs[rd_a] : '0;
   assign sel_b = (32'(rd_b) < NUM_CORES) ? regs[rd_b] : '0;

endmodule

// File: rtl/core_win_resp.sv
module core_win_resp
   import core_win_pkg::*;
#(
   parameter int CW = 2,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_req,
   input  kind_e         kind,
   input  logic [CW-1:0] tgt,
   input  logic [CW-1:0] tgt_redir,
   input  logic [DW-1:0] shared_count,
   input  logic [DW-1:0] bank_rdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data
);
   logic [DW-1:0] nxt;

   always_comb begin
      unique case (kind)
         K_REDIR:  nxt = DW'(tgt_redir);
         K_IDENT:  nxt = DW'(tgt);
         K_BANK:   nxt = bank_rdata;
         K_CNT_LO: nxt = shared_count;
         default:  nxt = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         rd_data  <= rd_req ? nxt : '0;
      end
   end

endmodule

// File: rtl/core_win.sv
module core_win
   import core_win_pkg::*;
#(
   parameter int NUM_CORES = 4,
   parameter int DW        = 32,
   parameter int AW        = 8,
   parameter int BANK_REGS = 4,
   localparam int CW  = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int BRW = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_valid,
   input  logic           req_wr,
   input  logic [CW-1:0]  req_core,
   input  logic [AW-1:0]  req_addr,
   input  logic [DW-1:0]  req_wdata,
   input  logic [DW-1:0]  shared_count,
   input  logic [DW-1:0]  bank_rdata,
   output logic           bank_valid,
   output logic           bank_we,
   output logic [CW-1:0]  bank_core,
   output logic [BRW-1:0] bank_reg,
   output logic [DW-1:0]  bank_wdata,
   output logic           rd_valid,
   output logic [DW-1:0]  rd_data
);
   if (NUM_CORES < 2) begin : g_bad_cores
      $error("core_win: NUM_CORES must be at least 2");
   end
   if (AW < 4) begin : g_bad_aw
      $error("core_win: AW too small for window and offset");
   end
   if (OFS_BANK0 + BANK_REGS > (1 << (AW - 2))) begin : g_bad_bank
      $error("core_win: bank registers do not fit the offset field");
   end
   if (DW <= CW) begin : g_bad_dw
      $error("core_win: DW must exceed the core index width");
   end

   win_e           win;
   kind_e          kind;
   logic [BRW-1:0] bank_idx;
   logic [CW-1:0]  redir_req;
   logic [CW-1:0]  redir_tgt;
   logic [CW-1:0]  tgt;

   core_win_decode #(.AW(AW), .BANK_REGS(BANK_REGS), .BRW(BRW)) u_dec (
      .addr     (req_addr),
      .win      (win),
      .kind     (kind),
      .bank_idx (bank_idx)
   );

   // local window hits the requester, other window follows its redirect
   assign tgt = (win == WIN_OTHER) ? redir_req : req_core;

   core_win_redir #(.NUM_CORES(NUM_CORES), .CW(CW), .DW(DW)) u_redir (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (req_valid && req_wr && kind == K_REDIR),
      .wr_core (tgt),
      .wdata   (req_wdata),
      .rd_a    (req_core),
      .rd_b    (tgt),
      .sel_a   (redir_req),
      .sel_b   (redir_tgt)
   );

   assign bank_valid = req_valid && kind == K_BANK;
   assign bank_we    = bank_valid && req_wr;
   assign bank_core  = tgt;
   assign bank_reg   = bank_idx;
   assign bank_wdata = req_wdata;

   core_win_resp #(.CW(CW), .DW(DW)) u_resp (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_req       (req_valid && !req_wr),
      .kind         (kind),
      .tgt          (tgt),
      .tgt_redir    (redir_tgt),
      .shared_count (shared_count),
      .bank_rdata   (bank_rdata),
      .rd_valid     (rd_valid),
      .rd_data      (rd_data)
   );

endmodule

// File: rtl/core_win_chk.sv
module core_win_chk #(
   parameter int CW = 2,
   parameter int DW = 32,
   parameter int AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_wr,
   input logic [CW-1:0] req_core,
   input logic [AW-1:0] req_addr,
   input logic [DW-1:0] shared_count,
   input logic          bank_valid,
   input logic [CW-1:0] bank_core,
   input logic          rd_valid,
   input logic [DW-1:0] rd_data
);
   logic [1:0]    c_win;
   logic [AW-3:0] c_off;
   logic          c_rd;

   assign c_win = req_addr[AW-1:AW-2];
   assign c_off = req_addr[AW-3:0];
   assign c_rd  = req_valid && !req_wr;

   // R8
   rd_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_rd |=> rd_valid);
   // R8
   rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !c_rd |=> !rd_valid);
   // R1
   local_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && c_win == 2'd0 && bank_valid) |-> bank_core == req_core);
   // R5
   user_nobank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && c_win == 2'd2) |-> !bank_valid);
   // R5
   cnt_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_rd && c_win == 2'd2 && c_off == '0) |=> rd_data == $past(shared_count));
   // R6
   ctl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_rd && !c_win[1] && c_off == '0) |=> rd_data == '0);
   // R7
   none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_rd && c_win == 2'd3) |=> rd_data == '0);
   // R7
   none_nobank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && c_win == 2'd3) |-> !bank_valid);

endmodule

bind core_win core_win_chk #(.CW(CW), .DW(DW), .AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_wr       (req_wr),
   .req_core     (req_core),
   .req_addr     (req_addr),
   .shared_count (shared_count),
   .bank_valid   (bank_valid),
   .bank_core    (bank_core),
   .rd_valid     (rd_valid),
   .rd_data      (rd_data)
);

// File: tb/core_win_tb.sv
`timescale 1ns/1ps
module core_win_tb;
   localparam int NC  = 3;
   localparam int DW  = 32;
   localparam int AW  = 6;
   localparam int NB  = 2;
   localparam int CW  = 2;
   localparam int BRW = 1;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_wr = 1'b0;
   logic [CW-1:0]  req_core = '0;
   logic [AW-1:0]  req_addr = '0;
   logic [DW-1:0]  req_wdata = '0;
   logic [DW-1:0]  shared_count = '0;
   logic [DW-1:0]  bank_rdata;
   logic           bank_valid, bank_we, rd_valid;
   logic [CW-1:0]  bank_core;
   logic [BRW-1:0] bank_reg;
   logic [DW-1:0]  bank_wdata, rd_data;

   int errors = 0;
   int checks = 0;
   int redir_m [NC];

   always #2 clk = ~clk;

   // bank answers with a tag made of core and register index
   always_comb bank_rdata = 32'hB000_0000 | (32'(bank_core) << 8) | 32'(bank_reg);

   core_win #(.NUM_CORES(NC), .DW(DW), .AW(AW), .BANK_REGS(NB)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
      .req_core(req_core), .req_addr(req_addr), .req_wdata(req_wdata),
      .shared_count(shared_count), .bank_rdata(bank_rdata),
      .bank_valid(bank_valid), .bank_we(bank_we), .bank_core(bank_core),
      .bank_reg(bank_reg), .bank_wdata(bank_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic check(input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int a);
      int w = a >> 4;
      int o = a & 15;
      if (w < 2) begin
         if (o == 0) return "R6";
         if (o == 1) return "R3";
         if (o == 2) return "R4";
         if (o >= 3 && o < 3 + NB) return (w == 0) ? "R1" : "R2";
         return "R7";
      end
      if (w == 2 && o < 2) return "R5";
      return "R7";
   endfunction

   task automatic access(input int c, input int a, input bit wr,
                         input logic [DW-1:0] wd, input string ovr);
      int w = a >> 4;
      int o = a & 15;
      int t = (w == 0) ? c : redir_m[c];
      bit bv = (w < 2) && (o >= 3) && (o < 3 + NB);
      logic [DW-1:0] exp = '0;
      string tg = (ovr != "") ? ovr : tag_of(a);
      @(negedge clk);
      req_valid = 1'b1; req_wr = wr; req_core = CW'(c); req_addr = AW'(a);
      req_wdata = wd; shared_count = 32'h5A00_0000 + 32'(a * 7 + c);
      if (w < 2) begin
         if (o == 1) exp = 32'(redir_m[t]);
         else if (o == 2) exp = 32'(t);
         else if (bv) exp = 32'hB000_0000 | (32'(t) << 8) | 32'(o - 3);
      end else if (w == 2 && o == 0) begin
         exp = shared_count;
      end
      #1;
      check(tg, "bank_valid", 32'(bank_valid), 32'(bv));
      if (bv) begin
         check(tg, "bank_core", 32'(bank_core), 32'(t));
         check(tg, "bank_reg", 32'(bank_reg), 32'(o - 3));
         check(tg, "bank_we", 32'(bank_we), 32'(wr));
         check(tg, "bank_wdata", bank_wdata, wd);
      end
      // model of the redirect write filter
      if (wr && w < 2 && o == 1 && wd < 32'(NC)) redir_m[t] = int'(wd);
      @(negedge clk);
      req_valid = 1'b0;
      check("R8", "rd_valid", 32'(rd_valid), 32'(!wr));
      if (!wr) check(tg, "rd_data", rd_data, exp);
   endtask

   task automatic sweep_reads();
      for (int c = 0; c < NC; c++)
         for (int a = 0; a < 64; a++) access(c, a, 1'b0, '0, "");
   endtask

   initial begin
      for (int i = 0; i < NC; i++) redir_m[i] = 0;
      repeat (3) @(negedge clk);
      check("R8", "rd_valid at reset", 32'(rd_valid), 32'd0);
      rst_n = 1'b1;
      // R3 reset value, R1 R2 R4 with all redirects at 0
      sweep_reads();
      // R3 in-range writes take, out-of-range writes are dropped
      access(0, 16'h01, 1'b1, 32'd2, "R3");
      access(1, 16'h01, 1'b1, 32'd1, "R3");
      access(2, 16'h01, 1'b1, 32'd3, "R3");
      access(2, 16'h01, 1'b1, 32'h0001_0001, "R3");
      access(0, 16'h01, 1'b0, '0, "R3");
      access(2, 16'h01, 1'b0, '0, "R3");
      sweep_reads();
      // R9 core 0 writes through the other window into core 2's register
      access(0, 16'h11, 1'b1, 32'd1, "R9");
      access(2, 16'h01, 1'b0, '0, "R9");
      access(0, 16'h01, 1'b0, '0, "R9");
      access(2, 16'h12, 1'b0, '0, "R9");
      // R5 R6 R7 all-ones writes everywhere leave every value unchanged
      for (int c = 0; c < NC; c++)
         for (int a = 0; a < 64; a++) access(c, a, 1'b1, 32'hFFFF_FFFF, "");
      sweep_reads();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(4 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule